// File: doc/BRIEF.md
# Two-Phase Randomized Mesh Route Computation

This block makes the routing decision for a router in a two-dimensional mesh that spreads traffic with an oblivious two-leg scheme. When a packet is injected, an intermediate node is picked from a pseudo-random sequence. The packet first travels to that node and then on to its real destination. Each leg uses dimension-order routing: the X offset is closed first, then the Y offset. A phase bit in the header records which leg the packet is on. The phase bit changes from 0 to 1 at the node where the packet arrives at its intermediate.

The block has two independent halves. The injection half is used at the source node. It takes the source and destination coordinates, a high-load indication and a quadrant-lock control, and returns the intermediate coordinates and the starting phase one cycle later. The per-hop half is combinational. It takes the local router coordinates and a header made of intermediate, destination and phase, and returns the output port and the updated phase. Routing never looks at live network state. The decision depends only on the pseudo-random pick and the coordinates. When load is low, the random leg is skipped and the packet goes straight to its destination.

Top module: `oblivious_mesh_route`

## Requirements
- R1: After reset, pick_valid is 0 until an injection request is seen.
- R2: On each hop the target is the intermediate while the phase is 0, and the destination while the phase is 1. When the target X differs from the local X, the port is east (code 1) if the target X is larger and west (code 2) if it is smaller, whatever the Y values are.
- R3: Once X matches the target, the port is north (code 3) if the target Y is larger and south (code 4) if it is smaller.
- R4: A header with phase 0 that arrives at the node equal to its intermediate leaves with out_phase 1, and is routed toward the destination in the same cycle.
- R5: The local port (code 0) is chosen only when out_phase is 1 and the local node equals the destination. A phase-0 packet that passes over its destination keeps heading for its intermediate.
- R6: With load_high at 0, an injection returns pick_mid equal to the destination and pick_phase 1.
- R7: With load_high at 1, the intermediate comes from a 16-bit maximal-length pseudo-random sequence that advances once per high-load injection and is folded into the coordinate range. Successive picks are not all the same node.
- R8: With load_high and quad_lock both at 1, the most significant bit of each intermediate coordinate equals the matching bit of the destination, so the intermediate lies in the destination's quadrant.
- R9: Under high load, pick_phase is 1 exactly when the picked intermediate equals the source, and 0 otherwise.
- R10: pick_valid is 1 for exactly the cycle after each cycle in which inj_valid is 1, and 0 after a cycle without a request.
- R11: A header that arrives with phase 1 always leaves with out_phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | 1 | Injection pick request |
| inj_src_x | input | XW | Source X coordinate |
| inj_src_y | input | YW | Source Y coordinate |
| inj_dst_x | input | XW | Destination X coordinate |
| inj_dst_y | input | YW | Destination Y coordinate |
| load_high | input | 1 | Local occupancy above threshold; enables the random leg |
| quad_lock | input | 1 | Confine the intermediate to the destination's quadrant |
| pick_valid | output | 1 | Pick result valid |
| pick_mid_x | output | XW | Chosen intermediate X |
| pick_mid_y | output | YW | Chosen intermediate Y |
| pick_phase | output | 1 | Starting phase bit for the header |
| cur_x | input | XW | Local router X |
| cur_y | input | YW | Local router Y |
| hdr_mid_x | input | XW | Header intermediate X |
| hdr_mid_y | input | YW | Header intermediate Y |
| hdr_dst_x | input | XW | Header destination X |
| hdr_dst_y | input | YW | Header destination Y |
| hdr_phase | input | 1 | Header phase bit |
| out_port | output | 3 | Chosen port: 0 local, 1 east, 2 west, 3 north, 4 south |
| out_phase | output | 1 | Updated phase bit |

## Verification
The bench targets the hop where a phase-0 packet reaches its intermediate. A design that did not flip the phase there would bounce the packet or eject it at the wrong node. It also places a phase-0 packet on its own destination while the intermediate lies elsewhere. A design that tested only the coordinates would eject that packet early. The bench checks that X is resolved before Y even when both offsets are non-zero, which catches a swapped dimension order. Under high load it gathers many picks and checks that they vary, that every pick stays in the destination quadrant when locking is on, and that the starting phase is set to 1 only for a pick that lands on the source.

// File: rtl/omr_pkg.sv
package omr_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/omr_lfsr.sv
module omr_lfsr
  import omr_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = state;
    if (step) begin
      state_d = {1'b0, state[LFSR_W-1:1]} ^ (state[0] ? LFSR_TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/omr_mid_pick.sv
module omr_mid_pick
  import omr_pkg::*;
#(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] rnd,
  input  logic              inj_valid,
  input  logic [XW-1:0]     src_x,
  input  logic [YW-1:0]     src_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  input  logic              load_high,
  input  logic              quad_lock,
  output logic              pick_valid,
  output logic [XW-1:0]     mid_x,
  output logic [YW-1:0]     mid_y,
  output logic              mid_phase
);
  localparam int unsigned CW = XW + YW;

  logic [CW-1:0] folded;
  logic [XW-1:0] cand_x;
  logic [YW-1:0] cand_y;
  logic          valid_d;
  logic [XW-1:0] mid_x_d;
  logic [YW-1:0] mid_y_d;
  logic          phase_d;

  always_comb begin
    folded = '0;
    for (int i = 0; i < LFSR_W; i++) begin
      folded[i % CW] = folded[i % CW] ^ rnd[i];
    end
  end

  always_comb begin
    cand_x = folded[XW-1:0];
    cand_y = folded[CW-1:XW];
    if (quad_lock) begin
      cand_x[XW-1] = dst_x[XW-1];
      cand_y[YW-1] = dst_y[YW-1];
    end
  end

  always_comb begin
    valid_d = inj_valid;
    mid_x_d = mid_x;
    mid_y_d = mid_y;
    phase_d = mid_phase;
    if (inj_valid) begin
      if (load_high) begin
        mid_x_d = cand_x;
        mid_y_d = cand_y;
        phase_d = (cand_x == src_x) && (cand_y == src_y);
      end else begin
        mid_x_d = dst_x;
        mid_y_d = dst_y;
        phase_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_valid <= 1'b0;
      mid_x      <= '0;
      mid_y      <= '0;
      mid_phase  <= 1'b0;
    end else begin
      pick_valid <= valid_d;
      mid_x      <= mid_x_d;
      mid_y      <= mid_y_d;
      mid_phase  <= phase_d;
    end
  end
endmodule

// File: rtl/omr_dor_step.sv
module omr_dor_step
  import omr_pkg::*;
#(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] mid_x,
  input  logic [YW-1:0] mid_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic          phase_in,
  output port_e         port,
  output logic          phase_out
);
  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;

  always_comb begin
    phase_out = phase_in | ((cur_x == mid_x) && (cur_y == mid_y));
    tgt_x     = phase_out ? dst_x : mid_x;
    tgt_y     = phase_out ? dst_y : mid_y;
    if (tgt_x > cur_x)      port = PORT_EAST;
    else if (tgt_x < cur_x) port = PORT_WEST;
    else if (tgt_y > cur_y) port = PORT_NORTH;
    else if (tgt_y < cur_y) port = PORT_SOUTH;
    else                    port = PORT_LOCAL;
  end
endmodule

// File: rtl/oblivious_mesh_route.sv
module oblivious_mesh_route
  import omr_pkg::*;
#(
  parameter int unsigned       XW   = 2,
  parameter int unsigned       YW   = 2,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_valid,
  input  logic [XW-1:0] inj_src_x,
  input  logic [YW-1:0] inj_src_y,
  input  logic [XW-1:0] inj_dst_x,
  input  logic [YW-1:0] inj_dst_y,
  input  logic          load_high,
  input  logic          quad_lock,
  output logic          pick_valid,
  output logic [XW-1:0] pick_mid_x,
  output logic [YW-1:0] pick_mid_y,
  output logic          pick_phase,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] hdr_mid_x,
  input  logic [YW-1:0] hdr_mid_y,
  input  logic [XW-1:0] hdr_dst_x,
  input  logic [YW-1:0] hdr_dst_y,
  input  logic          hdr_phase,
  output logic [2:0]    out_port,
  output logic          out_phase
);
  logic              rst_meta_n;
  logic              rst_sync_n;
  logic [LFSR_W-1:0] rnd;
  logic              rnd_step;
  port_e             port_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign rnd_step = inj_valid & load_high;

  omr_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (rnd_step),
    .state (rnd)
  );

  omr_mid_pick #(.XW(XW), .YW(YW)) u_pick (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rnd        (rnd),
    .inj_valid  (inj_valid),
    .src_x      (inj_src_x),
    .src_y      (inj_src_y),
    .dst_x      (inj_dst_x),
    .dst_y      (inj_dst_y),
    .load_high  (load_high),
    .quad_lock  (quad_lock),
    .pick_valid (pick_valid),
    .mid_x      (pick_mid_x),
    .mid_y      (pick_mid_y),
    .mid_phase  (pick_phase)
  );

  omr_dor_step #(.XW(XW), .YW(YW)) u_step (
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .mid_x     (hdr_mid_x),
    .mid_y     (hdr_mid_y),
    .dst_x     (hdr_dst_x),
    .dst_y     (hdr_dst_y),
    .phase_in  (hdr_phase),
    .port      (port_sel),
    .phase_out (out_phase)
  );

  assign out_port = port_sel;
endmodule

// File: rtl/omr_checker.sv
module omr_checker #(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inj_valid,
  input logic [XW-1:0] inj_src_x,
  input logic [YW-1:0] inj_src_y,
  input logic [XW-1:0] inj_dst_x,
  input logic [YW-1:0] inj_dst_y,
  input logic          load_high,
  input logic          quad_lock,
  input logic          pick_valid,
  input logic [XW-1:0] pick_mid_x,
  input logic [YW-1:0] pick_mid_y,
  input logic          pick_phase,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [XW-1:0] hdr_dst_x,
  input logic [YW-1:0] hdr_dst_y,
  input logic          hdr_phase,
  input logic [2:0]    out_port,
  input logic          out_phase
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> pick_valid);

  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |=> !pick_valid);

  a_r6_low_load_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !load_high) |=> (pick_phase && pick_mid_x == $past(inj_dst_x)
                                   && pick_mid_y == $past(inj_dst_y)));

  a_r8_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && load_high && quad_lock) |=>
      (pick_mid_x[XW-1] == $past(inj_dst_x[XW-1]) && pick_mid_y[YW-1] == $past(inj_dst_y[YW-1])));

  a_r9_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && load_high) |=>
      (pick_phase == (pick_mid_x == $past(inj_src_x) && pick_mid_y == $past(inj_src_y))));

  a_r5_eject_only_home: assert property (@(posedge clk) disable iff (!rst_n)
    (out_port == 3'd0) |-> (out_phase && cur_x == hdr_dst_x && cur_y == hdr_dst_y));

  a_r11_phase_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase |-> out_phase);
endmodule

bind oblivious_mesh_route omr_checker #(.XW(XW), .YW(YW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .inj_valid  (inj_valid),
  .inj_src_x  (inj_src_x),
  .inj_src_y  (inj_src_y),
  .inj_dst_x  (inj_dst_x),
  .inj_dst_y  (inj_dst_y),
  .load_high  (load_high),
  .quad_lock  (quad_lock),
  .pick_valid (pick_valid),
  .pick_mid_x (pick_mid_x),
  .pick_mid_y (pick_mid_y),
  .pick_phase (pick_phase),
  .cur_x      (cur_x),
  .cur_y      (cur_y),
  .hdr_dst_x  (hdr_dst_x),
  .hdr_dst_y  (hdr_dst_y),
  .hdr_phase  (hdr_phase),
  .out_port   (out_port),
  .out_phase  (out_phase)
);

// File: tb/tb_oblivious_mesh_route.sv
module tb_oblivious_mesh_route;
  localparam int XW = 2;
  localparam int YW = 2;

  logic          clk;
  logic          rst_n;
  logic          inj_valid;
  logic [XW-1:0] inj_src_x, inj_dst_x;
  logic [YW-1:0] inj_src_y, inj_dst_y;
  logic          load_high, quad_lock;
  logic          pick_valid, pick_phase;
  logic [XW-1:0] pick_mid_x;
  logic [YW-1:0] pick_mid_y;
  logic [XW-1:0] cur_x, hdr_mid_x, hdr_dst_x;
  logic [YW-1:0] cur_y, hdr_mid_y, hdr_dst_y;
  logic          hdr_phase;
  logic [2:0]    out_port;
  logic          out_phase;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  oblivious_mesh_route #(.XW(XW), .YW(YW)) dut (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid),
    .inj_src_x(inj_src_x), .inj_src_y(inj_src_y),
    .inj_dst_x(inj_dst_x), .inj_dst_y(inj_dst_y),
    .load_high(load_high), .quad_lock(quad_lock),
    .pick_valid(pick_valid), .pick_mid_x(pick_mid_x), .pick_mid_y(pick_mid_y),
    .pick_phase(pick_phase), .cur_x(cur_x), .cur_y(cur_y),
    .hdr_mid_x(hdr_mid_x), .hdr_mid_y(hdr_mid_y),
    .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y), .hdr_phase(hdr_phase),
    .out_port(out_port), .out_phase(out_phase)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hop(input int cx, input int cy, input int mx, input int my,
                     input int dx, input int dy, input int ph,
                     input int exp_port, input int exp_ph, input string req);
    @(negedge clk);
    cur_x = cx[XW-1:0]; cur_y = cy[YW-1:0];
    hdr_mid_x = mx[XW-1:0]; hdr_mid_y = my[YW-1:0];
    hdr_dst_x = dx[XW-1:0]; hdr_dst_y = dy[YW-1:0];
    hdr_phase = ph[0];
    #1;
    check(int'(out_port) == exp_port, {req, " port"}, int'(out_port), exp_port);
    check(int'(out_phase) == exp_ph, {req, " phase"}, int'(out_phase), exp_ph);
  endtask

  task automatic inject(input int sx, input int sy, input int dx, input int dy,
                        input bit hi, input bit ql);
    @(negedge clk);
    inj_valid = 1'b1;
    inj_src_x = sx[XW-1:0]; inj_src_y = sy[YW-1:0];
    inj_dst_x = dx[XW-1:0]; inj_dst_y = dy[YW-1:0];
    load_high = hi; quad_lock = ql;
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(pick_valid == 1'b0, "R1 pick_valid after reset", int'(pick_valid), 0);
  endtask

  task automatic t_dor();
    hop(1, 1, 3, 0, 0, 3, 0, 1, 0, "R2 east toward mid X first");
    hop(3, 2, 0, 2, 3, 3, 1, 3, 1, "R2 phase1 targets dst");
    hop(3, 1, 0, 3, 2, 2, 0, 2, 0, "R2 west toward mid");
    hop(3, 2, 3, 0, 0, 3, 0, 4, 0, "R3 south after X matched");
    hop(0, 1, 2, 2, 0, 3, 1, 3, 1, "R3 north to dst");
  endtask

  task automatic t_phase();
    hop(3, 0, 3, 0, 0, 3, 0, 2, 1, "R4 flip at mid then west");
    hop(2, 2, 1, 2, 2, 2, 0, 2, 0, "R5 phase0 at dst keeps going");
    hop(0, 3, 1, 1, 0, 3, 1, 0, 1, "R5 eject at dst phase1");
    hop(1, 1, 1, 1, 1, 1, 0, 0, 1, "R4 mid equals dst ejects");
    hop(2, 1, 2, 1, 0, 1, 1, 2, 1, "R11 phase stays 1 at mid");
  endtask

  task automatic t_low_load();
    for (int i = 0; i < 6; i++) begin
      inject(i % 4, 1, 3 - (i % 4), (i + 2) % 4, 1'b0, i[0]);
      check(pick_valid == 1'b1, "R10 valid after request", int'(pick_valid), 1);
      check(pick_mid_x == 2'(3 - (i % 4)) && pick_mid_y == 2'((i + 2) % 4),
            "R6 mid equals dst", int'({pick_mid_x, pick_mid_y}),
            int'({2'(3 - (i % 4)), 2'((i + 2) % 4)}));
      check(pick_phase == 1'b1, "R6 phase 1 under low load", int'(pick_phase), 1);
    end
    @(negedge clk);
    check(pick_valid == 1'b0, "R10 valid single cycle", int'(pick_valid), 0);
  endtask

  task automatic t_high_load();
    bit [15:0] seen = '0;
    int distinct = 0;
    for (int i = 0; i < 32; i++) begin
      inject(1, 2, 3, 0, 1'b1, 1'b0);
      seen[{pick_mid_x, pick_mid_y}] = 1'b1;
      check(pick_phase == ((pick_mid_x == 2'd1) && (pick_mid_y == 2'd2)),
            "R9 phase vs source match", int'(pick_phase),
            int'((pick_mid_x == 2'd1) && (pick_mid_y == 2'd2)));
    end
    for (int k = 0; k < 16; k++) distinct += int'(seen[k]);
    check(distinct >= 4, "R7 picks vary", distinct, 4);
  endtask

  task automatic t_quadrant();
    for (int i = 0; i < 24; i++) begin
      inject(0, 3, 3, 0, 1'b1, 1'b1);
      check(pick_mid_x >= 2'd2 && pick_mid_y <= 2'd1, "R8 mid in dst quadrant",
            int'({pick_mid_x, pick_mid_y}), 12);
      check(pick_phase == 1'b0, "R9 phase 0 when mid not source", int'(pick_phase), 0);
    end
    for (int i = 0; i < 24; i++) begin
      inject(0, 0, 1, 1, 1'b1, 1'b1);
      check(pick_mid_x <= 2'd1 && pick_mid_y <= 2'd1, "R8 lower-left quadrant",
            int'({pick_mid_x, pick_mid_y}), 0);
      check(pick_phase == ((pick_mid_x == 2'd0) && (pick_mid_y == 2'd0)),
            "R9 phase vs source in quadrant", int'(pick_phase),
            int'((pick_mid_x == 2'd0) && (pick_mid_y == 2'd0)));
    end
  endtask

  initial begin
    rst_n = 1'b0; inj_valid = 1'b0; load_high = 1'b0; quad_lock = 1'b0;
    inj_src_x = '0; inj_src_y = '0; inj_dst_x = '0; inj_dst_y = '0;
    cur_x = '0; cur_y = '0; hdr_mid_x = '0; hdr_mid_y = '0;
    hdr_dst_x = '0; hdr_dst_y = '0; hdr_phase = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dor();
    t_phase();
    t_low_load();
    t_high_load();
    t_quadrant();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule